// File: doc/BRIEF.md
# Fibre Channel Receive Link Synchronizer

This block watches the decoded word stream of one Fibre Channel receive lane and decides whether the link is in word synchronization. Each word holds four characters that an earlier stage has already decoded and aligned. The word comes with a four-bit flag vector that marks control characters, a code-violation indication and a comma-misalignment indication. A word-valid strobe qualifies all of these inputs.

Out of reset the link is unsynchronized. To acquire the link, the block must see three idle ordered sets back to back with no error in between. While the link is synchronized, the block counts running-disparity code violations. Each run of two good words removes one counted violation. When the count reaches four, synchronization is dropped and the block starts a new acquisition search at once. The result drives a sync line and a separately registered status bit. Both read 0 whenever the link is not synchronized.

Top module: `fc_link_sync`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `sync_o` and `stat_sync_o` are 0.
- R2: A word is an idle ordered set when all of these hold: `rx_word[31:24]` = 0xBC with `rx_ctl[3]` = 1; `rx_word[23:16]` = 0x95, `rx_word[15:8]` = 0xB5 and `rx_word[7:0]` = 0xB5; `rx_ctl[2:0]` = 0. Both error indications must also be low. A word with `rx_ctl[3]` = 0 is not an idle.
- R3: Three consecutive qualified idle words make `sync_o` rise on the cycle after the third one. After only two, `sync_o` is still 0.
- R4: During acquisition, a qualified word with `code_viol` or `comma_mis` set restarts the idle count from zero.
- R5: During acquisition, a qualified error-free word that is not an idle also restarts the idle count from zero.
- R6: A cycle with `word_vld` = 0 changes nothing, whatever the other inputs carry.
- R7: While synchronized, four qualified words with `code_viol` set and no intervening good pair make `sync_o` fall on the cycle after the fourth.
- R8: While synchronized, two consecutive good words remove one counted violation. A single good word does not. A violation discards a half-completed pair.
- R9: While synchronized with no violations counted, good words build no credit. Four later violations still drop the link.
- R10: `stat_sync_o` equals `sync_o` on every cycle.
- R11: After a loss, acquisition restarts from an idle count of zero. While synchronized, `comma_mis` alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | Qualifies the word and flags on this cycle |
| rx_word | input | 32 | Decoded word; first received character in [31:24] |
| rx_ctl | input | 4 | Control-character flag per byte; bit 3 marks [31:24] |
| code_viol | input | 1 | Running-disparity code violation in this word |
| comma_mis | input | 1 | Comma seen at a misaligned position |
| sync_o | output | 1 | Link in word synchronization |
| stat_sync_o | output | 1 | Status bit, 0 while not synchronized |

## Verification
Two pairs of functions can fall on the same word. In the synchronized state, the word that would complete a good pair can instead carry a violation. The bench sends good, violation, good, violation after two earlier violations. The link must drop on that last violation, which shows the half pair was discarded rather than credited. During acquisition, the third idle can arrive right after an error has restarted the count. The bench sends two idles, an error and two more idles, and requires `sync_o` to stay low until a third fresh idle arrives.

// File: rtl/fc_sync_pkg.sv
package fc_sync_pkg;
   typedef enum logic [0:0] {
      LNK_HUNT   = 1'b0,
      LNK_LOCKED = 1'b1
   } lnk_state_t;

   localparam logic [7:0] CH_K28_5 = 8'hBC;
   localparam logic [7:0] CH_D21_4 = 8'h95;
   localparam logic [7:0] CH_D21_5 = 8'hB5;
   localparam logic [31:0] IDLE_WORD = {CH_K28_5, CH_D21_4, CH_D21_5, CH_D21_5};
   localparam logic [3:0]  IDLE_CTL  = 4'b1000;
endpackage

// File: rtl/fc_idle_match.sv
module fc_idle_match
   import fc_sync_pkg::*;
#(
   parameter int  WORD_W     = 32,
   parameter int  CTL_W      = WORD_W / 8,
   parameter bit  STRICT_CTL = 1'b1
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [CTL_W-1:0]  ctl_i,
   output logic              is_idle_o
);
   logic data_ok;
   logic ctl_ok;

   if (WORD_W != 32) begin : g_bad_w
      $error("fc_idle_match: WORD_W must be 32");
   end

   assign data_ok = (word_i == IDLE_WORD);

   if (STRICT_CTL) begin : g_strict
      assign ctl_ok = (ctl_i == IDLE_CTL);
   end else begin : g_loose
      assign ctl_ok = ctl_i[CTL_W-1];
   end

   assign is_idle_o = data_ok && ctl_ok;
endmodule

// File: rtl/fc_acq_counter.sv
module fc_acq_counter #(
   parameter int ACQ_N = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic step_i,
   input  logic idle_i,
   input  logic err_i,
   output logic done_o
);
   localparam int ACQ_W = (ACQ_N > 1) ? $clog2(ACQ_N) : 1;
   localparam logic [ACQ_W-1:0] LAST = ACQ_W'(ACQ_N - 1);

   logic [ACQ_W-1:0] cnt_q;
   logic             hit;

   if (ACQ_N < 1) begin : g_bad_n
      $error("fc_acq_counter: ACQ_N must be at least 1");
   end

   assign hit    = step_i && idle_i && !err_i;
   assign done_o = hit && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (step_i) begin
         if (!hit || done_o) cnt_q <= '0;
         else                cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/fc_viol_tracker.sv
module fc_viol_tracker #(
   parameter int LOSS_N = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic step_i,
   input  logic viol_i,
   output logic lose_o
);
   localparam int VC_W = $clog2(LOSS_N + 1);
   localparam logic [VC_W-1:0] LAST = VC_W'(LOSS_N - 1);

   logic [VC_W-1:0] cnt_q;
   logic            half_q;

   if (LOSS_N < 2) begin : g_bad_n
      $error("fc_viol_tracker: LOSS_N must be at least 2");
   end

   assign lose_o = step_i && viol_i && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         half_q <= 1'b0;
      end else if (step_i) begin
         if (viol_i) begin
            half_q <= 1'b0;
            if (lose_o) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
         end else if (cnt_q != '0) begin
            if (half_q) begin
               cnt_q  <= cnt_q - 1'b1;
               half_q <= 1'b0;
            end else begin
               half_q <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fc_link_sync.sv
module fc_link_sync
   import fc_sync_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int CTL_W      = WORD_W / 8,
   parameter int ACQ_N      = 3,
   parameter int LOSS_N     = 4,
   parameter bit STRICT_CTL = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              word_vld,
   input  logic [WORD_W-1:0] rx_word,
   input  logic [CTL_W-1:0]  rx_ctl,
   input  logic              code_viol,
   input  logic              comma_mis,
   output logic              sync_o,
   output logic              stat_sync_o
);
   lnk_state_t st_q, st_d;
   logic       is_idle;
   logic       acq_done;
   logic       lose;
   logic       hunt_step;
   logic       lock_step;
   logic       stat_q;

   fc_idle_match #(
      .WORD_W     (WORD_W),
      .CTL_W      (CTL_W),
      .STRICT_CTL (STRICT_CTL)
   ) u_idle (
      .word_i    (rx_word),
      .ctl_i     (rx_ctl),
      .is_idle_o (is_idle)
   );

   assign hunt_step = word_vld && (st_q == LNK_HUNT);
   assign lock_step = word_vld && (st_q == LNK_LOCKED);

   fc_acq_counter #(.ACQ_N(ACQ_N)) u_acq (
      .clk    (clk),
      .rst    (rst),
      .step_i (hunt_step),
      .idle_i (is_idle),
      .err_i  (code_viol || comma_mis),
      .done_o (acq_done)
   );

   fc_viol_tracker #(.LOSS_N(LOSS_N)) u_viol (
      .clk    (clk),
      .rst    (rst),
      .step_i (lock_step),
      .viol_i (code_viol),
      .lose_o (lose)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         LNK_HUNT:   if (acq_done) st_d = LNK_LOCKED;
         LNK_LOCKED: if (lose)     st_d = LNK_HUNT;
         default:                  st_d = LNK_HUNT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= LNK_HUNT;
         stat_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         stat_q <= (st_d == LNK_LOCKED);
      end
   end

   assign sync_o      = (st_q == LNK_LOCKED);
   assign stat_sync_o = stat_q;
endmodule

// File: rtl/fc_link_sync_chk.sv
module fc_link_sync_chk (
   input logic clk,
   input logic rst,
   input logic word_vld,
   input logic code_viol,
   input logic comma_mis,
   input logic sync_o,
   input logic stat_sync_o
);
   // R10
   stat_match_chk: assert property (@(posedge clk) disable iff (rst)
      stat_sync_o == sync_o);

   // R6
   hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !word_vld |=> $stable(sync_o));

   // R3
   rise_clean_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sync_o) |-> $past(word_vld && !code_viol && !comma_mis));

   // R7
   fall_viol_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(sync_o) |-> $past(word_vld && code_viol));

   // R11
   misalign_locked_chk: assert property (@(posedge clk) disable iff (rst)
      (sync_o && word_vld && comma_mis && !code_viol) |=> sync_o);
endmodule

bind fc_link_sync fc_link_sync_chk u_chk (
   .clk         (clk),
   .rst         (rst),
   .word_vld    (word_vld),
   .code_viol   (code_viol),
   .comma_mis   (comma_mis),
   .sync_o      (sync_o),
   .stat_sync_o (stat_sync_o)
);

// File: tb/fc_link_sync_tb.sv
module fc_link_sync_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        word_vld = 1'b0;
   logic [31:0] rx_word = '0;
   logic [3:0]  rx_ctl = '0;
   logic        code_viol = 1'b0;
   logic        comma_mis = 1'b0;
   logic        sync_o;
   logic        stat_sync_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   localparam logic [31:0] IDLE = 32'hBC95B5B5;
   localparam logic [31:0] DATA = 32'h11223344;

   always #2 clk = ~clk;

   fc_link_sync dut_i (
      .clk(clk), .rst(rst), .word_vld(word_vld), .rx_word(rx_word),
      .rx_ctl(rx_ctl), .code_viol(code_viol), .comma_mis(comma_mis),
      .sync_o(sync_o), .stat_sync_o(stat_sync_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic push(input logic v, input logic [31:0] w, input logic [3:0] c,
                       input logic cv, input logic cm);
      @(negedge clk);
      word_vld = v; rx_word = w; rx_ctl = c; code_viol = cv; comma_mis = cm;
      @(posedge clk); #1;
      word_vld = 1'b0; code_viol = 1'b0; comma_mis = 1'b0;
   endtask

   task automatic idle();  push(1'b1, IDLE, 4'b1000, 1'b0, 1'b0); endtask
   task automatic good();  push(1'b1, DATA, 4'b0000, 1'b0, 1'b0); endtask
   task automatic viol();  push(1'b1, DATA, 4'b0000, 1'b1, 1'b0); endtask

   task automatic chk(input logic exp, input string req);
      checks++;
      if (sync_o !== exp || stat_sync_o !== exp) begin
         errors++;
         $display("FAIL %s: actual sync=%b stat=%b expected %b", req, sync_o, stat_sync_o, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      @(negedge clk); rst = 1'b0;
      @(posedge clk); #1;
   endtask

   task automatic lock();
      do_reset(); idle(); idle(); idle();
   endtask

   task automatic t_reset();
      do_reset();
      chk(1'b0, "R1 reset");
   endtask

   task automatic t_acquire();
      do_reset(); idle(); idle();
      chk(1'b0, "R3 two idles");
      idle();
      chk(1'b1, "R3 three idles");
      chk(1'b1, "R10 status follows");
   endtask

   task automatic t_idle_form();
      do_reset(); idle(); idle();
      push(1'b1, IDLE, 4'b0000, 1'b0, 1'b0);
      idle();
      chk(1'b0, "R2 missing ctl flag");
      push(1'b1, 32'hBC95B5B4, 4'b1000, 1'b0, 1'b0);
      idle(); idle();
      chk(1'b0, "R2 wrong last byte");
      idle();
      chk(1'b1, "R2 true idles");
   endtask

   task automatic t_acq_err();
      do_reset(); idle(); idle();
      push(1'b1, IDLE, 4'b1000, 1'b1, 1'b0);
      idle(); idle();
      chk(1'b0, "R4 viol restarts");
      idle();
      chk(1'b1, "R4 fresh three");
      do_reset(); idle(); idle();
      push(1'b1, IDLE, 4'b1000, 1'b0, 1'b1);
      idle(); idle();
      chk(1'b0, "R4 misalign restarts");
   endtask

   task automatic t_nonidle();
      do_reset(); idle(); idle(); good(); idle(); idle();
      chk(1'b0, "R5 data restarts");
      idle();
      chk(1'b1, "R5 then lock");
   endtask

   task automatic t_strobe();
      do_reset(); idle(); idle();
      push(1'b0, DATA, 4'b0000, 1'b1, 1'b1);
      chk(1'b0, "R6 gap no lock");
      idle();
      chk(1'b1, "R6 gap ignored");
      for (int i = 0; i < 6; i++) push(1'b0, DATA, 4'b0000, 1'b1, 1'b0);
      chk(1'b1, "R6 unqualified viol ignored");
   endtask

   task automatic t_loss();
      lock(); viol(); viol(); viol();
      chk(1'b1, "R7 three viols");
      viol();
      chk(1'b0, "R7 fourth viol");
   endtask

   task automatic t_pair();
      lock(); viol(); viol(); viol(); good(); good(); viol();
      chk(1'b1, "R8 pair cancels one");
      viol();
      chk(1'b0, "R8 count reaches four");
      lock(); viol(); viol(); viol(); good(); viol();
      chk(1'b0, "R8 single good no credit");
      lock(); viol(); viol(); good(); viol(); good(); viol();
      chk(1'b0, "R8 half pair discarded");
   endtask

   task automatic t_floor();
      lock();
      for (int i = 0; i < 6; i++) good();
      viol(); viol(); viol();
      chk(1'b1, "R9 three after goods");
      viol();
      chk(1'b0, "R9 no banked credit");
   endtask

   task automatic t_relock();
      lock(); viol(); viol(); viol(); viol();
      idle(); idle();
      chk(1'b0, "R11 relock needs three");
      idle();
      chk(1'b1, "R11 relocked");
      for (int i = 0; i < 5; i++) push(1'b1, DATA, 4'b0000, 1'b0, 1'b1);
      chk(1'b1, "R11 misalign ignored locked");
   endtask

   initial begin
      t_reset();
      t_acquire();
      t_idle_form();
      t_acq_err();
      t_nonidle();
      t_strobe();
      t_loss();
      t_pair();
      t_floor();
      t_relock();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule